// File: doc/BRIEF.md
# Per-Flow Traffic Counter Table

This block keeps a byte counter and a packet counter for every index of a forwarding engine's flow table. For each forwarded packet, the engine presents the flow index, the packet length and the flow's count-enable flag on the update port. When the global enable is on and the flag is set, the entry's packet count goes up by one and its byte count goes up by the length. Both counts are held in an internal array, which is kept small by default.

Software reaches the counters through a small register port, one indirect read at a time. It writes an entry index to the control register with the start flag set. It then polls that flag until it drops, and after that reads three result registers. The 48-bit byte count and the 40-bit packet count are spread over those registers at fixed bit boundaries. A configuration bit selects read-to-clear: a completed read then empties the entry, so each read returns only the traffic that arrived since the previous read.

Top module: `flow_ctr_table`

## Requirements
- R1: After reset, all entries are zero, the busy flag is 0, and the configuration register at 0x334 reads 0.
- R2: Control register 0x33C holds the entry index in bits 13:0 and start/busy in bit 16. Writing it with bit 16 set while idle launches a read and latches the index. Reading it back returns the latched index.
- R3: Bit 16 of 0x33C reads 1 for exactly RD_LAT cycles after the launching write, then reads 0 with the results valid.
- R4: Result register 0x340 holds byte count bits 31:0. 0x344 holds byte bits 47:32 in its bits 15:0 and packet bits 15:0 in its bits 31:16. 0x348 holds packet bits 39:16 in its bits 23:0, with its bits 31:24 zero. The results change only when a read completes.
- R5: A packet adds 1 to the packet count and its length to the byte count. This happens only when configuration bit 0 (enable) is 1 and the packet's count-enable flag is 1. Otherwise the entry is unchanged.
- R6: When configuration bit 1 (read-to-clear) is 1, a completed read zeroes the entry. When the bit is 0, the entry keeps its value, and repeated reads return the same counts.
- R7: Suppose a counted packet hits the same entry in the same cycle that a read-to-clear completes. The read then returns the counts from before that packet, and the entry is left holding only that packet.
- R8: A start write while busy is ignored. It changes neither the latched index nor the target of the read, and it clears nothing.
- R9: Both counts saturate at their full widths (BYTE_W and PKT_W bits) instead of wrapping.
- R10: Index bits above the table depth are ignored: index i addresses entry i mod ENTRIES, both for updates and for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | A forwarded packet is presented this cycle |
| upd_index | input | 14 | Flow-table index of the packet |
| upd_len | input | LEN_W (16) | Packet length in bytes |
| upd_cnt_en | input | 1 | Per-flow count-enable flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
Random packets are spread over twice the table depth, with random lengths, a mostly-set count flag and the global enable toggled in bursts. This mix separates correct gating and index aliasing from counts that leak into neighbours or ignore a flag. A long burst into one entry carries both counts past bit 32 and bit 16, so a misplaced split across the result registers shows up. Directed cases cover the remaining behaviours:
- a packet that lands in the clearing cycle;
- a start written while busy;
- back-to-back reads with and without read-to-clear;
- a second, narrow-width instance driven into saturation, which tells saturation apart from wrap-around.

// File: rtl/flow_ctr_pkg.sv
package flow_ctr_pkg;

    localparam int IDX_W      = 14;
    localparam int START_BIT  = 16;
    localparam int BYTE_FULL  = 48;
    localparam int PKT_FULL   = 40;
    localparam int RADDR_W    = 12;

    localparam logic [RADDR_W-1:0] A_CFG  = 12'h334;
    localparam logic [RADDR_W-1:0] A_CTRL = 12'h33C;
    localparam logic [RADDR_W-1:0] A_RES0 = 12'h340;
    localparam logic [RADDR_W-1:0] A_RES1 = 12'h344;
    localparam logic [RADDR_W-1:0] A_RES2 = 12'h348;

    typedef struct packed {
        logic rd_clr;   // bit 1
        logic en;       // bit 0
    } cfg_t;

    typedef struct packed {
        logic [31:0] w2;
        logic [31:0] w1;
        logic [31:0] w0;
    } res_t;

    function automatic res_t pack_result(input logic [BYTE_FULL-1:0] b,
                                         input logic [PKT_FULL-1:0]  p);
        res_t r;
        r.w0 = b[31:0];
        r.w1 = {p[15:0], b[47:32]};
        r.w2 = {8'h00, p[39:16]};
        return r;
    endfunction

endpackage

// File: rtl/ctr_store.sv
module ctr_store
    import flow_ctr_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int BYTE_W  = 48,
    parameter int PKT_W   = 40,
    parameter int LEN_W   = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_go,
    input  logic [AW-1:0]     upd_addr,
    input  logic [LEN_W-1:0]  upd_len,
    input  logic              clr_go,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_bytes,
    output logic [PKT_W-1:0]  rd_pkts
);

    logic [BYTE_W-1:0] byt_q [ENTRIES];
    logic [PKT_W-1:0]  pkt_q [ENTRIES];

    logic [BYTE_W:0]   bsum;
    logic [BYTE_W-1:0] bnext;
    logic [PKT_W-1:0]  pnext;
    logic [BYTE_W-1:0] bfirst;

    always_comb begin
        bsum   = {1'b0, byt_q[upd_addr]} + {{(BYTE_W+1-LEN_W){1'b0}}, upd_len};
        bnext  = bsum[BYTE_W] ? {BYTE_W{1'b1}} : bsum[BYTE_W-1:0];
        pnext  = (&pkt_q[upd_addr]) ? pkt_q[upd_addr] : pkt_q[upd_addr] + PKT_W'(1);
        bfirst = {{(BYTE_W-LEN_W){1'b0}}, upd_len};
    end

    assign rd_bytes = byt_q[rd_addr];
    assign rd_pkts  = pkt_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                byt_q[i] <= '0;
                pkt_q[i] <= '0;
            end
        end else begin
            if (upd_go) begin
                byt_q[upd_addr] <= bnext;
                pkt_q[upd_addr] <= pnext;
            end
            if (clr_go) begin
                if (upd_go && (upd_addr == rd_addr)) begin
                    byt_q[rd_addr] <= bfirst;
                    pkt_q[rd_addr] <= PKT_W'(1);
                end else begin
                    byt_q[rd_addr] <= '0;
                    pkt_q[rd_addr] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/ctr_reader.sv
module ctr_reader
    import flow_ctr_pkg::*;
#(
    parameter int RD_LAT = 4,
    localparam int CW    = $clog2(RD_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [IDX_W-1:0] req_idx,
    output logic             busy,
    output logic [IDX_W-1:0] idx_q,
    output logic             take
);

    logic [CW-1:0] cnt_q;

    assign take = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            idx_q <= '0;
        end else if (!busy && start_req) begin
            busy  <= 1'b1;
            cnt_q <= CW'(RD_LAT - 1);
            idx_q <= req_idx;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/ctr_regs.sv
module ctr_regs
    import flow_ctr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic                 busy,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic                 take,
    input  logic [BYTE_FULL-1:0] snap_bytes,
    input  logic [PKT_FULL-1:0]  snap_pkts,
    output cfg_t                 cfg,
    output logic                 start_req,
    output logic [IDX_W-1:0]     req_idx,
    output res_t                 res,
    output logic [31:0]          reg_rdata
);

    assign start_req = reg_wr && (reg_addr == A_CTRL) && reg_wdata[START_BIT];
    assign req_idx   = reg_wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            res <= '0;
        end else begin
            if (reg_wr && (reg_addr == A_CFG)) begin
                cfg.en     <= reg_wdata[0];
                cfg.rd_clr <= reg_wdata[1];
            end
            if (take) res <= pack_result(snap_bytes, snap_pkts);
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CFG:   reg_rdata = {30'd0, cfg.rd_clr, cfg.en};
            A_CTRL:  reg_rdata = {15'd0, busy, 2'b00, rd_idx};
            A_RES0:  reg_rdata = res.w0;
            A_RES1:  reg_rdata = res.w1;
            A_RES2:  reg_rdata = res.w2;
            default: reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/flow_ctr_table.sv
module flow_ctr_table
    import flow_ctr_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int RD_LAT  = 4,
    parameter int BYTE_W  = 48,
    parameter int PKT_W   = 40,
    parameter int LEN_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_valid,
    input  logic [IDX_W-1:0]   upd_index,
    input  logic [LEN_W-1:0]   upd_len,
    input  logic               upd_cnt_en,
    input  logic               reg_wr,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata
);

    localparam int AW = $clog2(ENTRIES);

    cfg_t              cfg;
    res_t              res_w;
    logic              start_req, busy_w, take_w, upd_go, clr_go;
    logic [IDX_W-1:0]  req_idx, idx_w;
    logic [BYTE_W-1:0] ent_bytes;
    logic [PKT_W-1:0]  ent_pkts;

    assign upd_go = upd_valid && upd_cnt_en && cfg.en;
    assign clr_go = take_w && cfg.rd_clr;

    ctr_store #(
        .ENTRIES (ENTRIES),
        .BYTE_W  (BYTE_W),
        .PKT_W   (PKT_W),
        .LEN_W   (LEN_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .upd_go   (upd_go),
        .upd_addr (upd_index[AW-1:0]),
        .upd_len  (upd_len),
        .clr_go   (clr_go),
        .rd_addr  (idx_w[AW-1:0]),
        .rd_bytes (ent_bytes),
        .rd_pkts  (ent_pkts)
    );

    ctr_reader #(.RD_LAT(RD_LAT)) u_reader (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .req_idx   (req_idx),
        .busy      (busy_w),
        .idx_q     (idx_w),
        .take      (take_w)
    );

    ctr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy       (busy_w),
        .rd_idx     (idx_w),
        .take       (take_w),
        .snap_bytes (BYTE_FULL'(ent_bytes)),
        .snap_pkts  (PKT_FULL'(ent_pkts)),
        .cfg        (cfg),
        .start_req  (start_req),
        .req_idx    (req_idx),
        .res        (res_w),
        .reg_rdata  (reg_rdata)
    );

endmodule

// File: rtl/flow_ctr_chk.sv
module flow_ctr_chk
    import flow_ctr_pkg::*;
#(
    parameter int RD_LAT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [RADDR_W-1:0] reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               busy,
    input logic [IDX_W-1:0]   rd_idx,
    input res_t               res
);

    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + 16'd1;
        else           run_q <= '0;
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[START_BIT] && !busy) |=> busy); // R2

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < 16'(RD_LAT))); // R3

    AST_BUSY_FULL_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(run_q) == 16'(RD_LAT - 1))); // R3

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(res)); // R4

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == A_CTRL) |=> $stable(rd_idx)); // R8

endmodule

bind flow_ctr_table flow_ctr_chk #(.RD_LAT(RD_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy_w),
    .rd_idx    (idx_w),
    .res       (res_w)
);

// File: tb/sim_flow_ctr_table.sv
module sim_flow_ctr_table;

    localparam int LAT = 4;
    localparam int N   = 16;
    localparam logic [11:0] A_CFG  = 12'h334;
    localparam logic [11:0] A_CTRL = 12'h33C;
    localparam logic [11:0] A_RES0 = 12'h340;
    localparam logic [11:0] A_RES1 = 12'h344;
    localparam logic [11:0] A_RES2 = 12'h348;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v0 = 0, f0 = 0, v1 = 0, f1 = 0;
    logic [13:0] i0 = 0, i1 = 0;
    logic [15:0] l0 = 0, l1 = 0;
    logic        rwr = 0;
    logic [11:0] raddr = 0;
    logic [31:0] rwdata = 0;
    logic [31:0] rdata0, rdata1;

    int     n_chk = 0, n_fail = 0;
    longint eb [N];
    longint ep [N];
    bit     men = 0, mclr = 0;

    always #4 clk = ~clk;

    flow_ctr_table #(.ENTRIES(N), .RD_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .upd_valid(v0), .upd_index(i0), .upd_len(l0),
        .upd_cnt_en(f0), .reg_wr(rwr), .reg_addr(raddr), .reg_wdata(rwdata),
        .reg_rdata(rdata0));

    flow_ctr_table #(.ENTRIES(N), .RD_LAT(LAT), .BYTE_W(20), .PKT_W(10)) u1 (
        .clk(clk), .rst(rst), .upd_valid(v1), .upd_index(i1), .upd_len(l1),
        .upd_cnt_en(f1), .reg_wr(rwr), .reg_addr(raddr), .reg_wdata(rwdata),
        .reg_rdata(rdata1));

    function automatic longint sat(longint v, int w);
        longint mx = (longint'(1) << w) - 1;
        return (v > mx) ? mx : v;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [11:0] a, logic [31:0] d);
        @(negedge clk); rwr = 1; raddr = a; rwdata = d;
        @(negedge clk); rwr = 0;
    endtask

    task automatic rreg(logic [11:0] a, bit sel, output logic [31:0] d);
        raddr = a; #1;
        d = sel ? rdata1 : rdata0;
    endtask

    task automatic send(int idx, int len, bit fl);
        @(negedge clk); v0 = 1; i0 = 14'(idx); l0 = 16'(len); f0 = fl;
        if (men && fl) begin
            eb[idx % N] = sat(eb[idx % N] + len, 48);
            ep[idx % N] = sat(ep[idx % N] + 1, 40);
        end
    endtask

    task automatic quiet();
        @(negedge clk); v0 = 0; v1 = 0;
    endtask

    task automatic poll(bit sel, output int polls);
        logic [31:0] d;
        polls = 0;
        forever begin
            rreg(A_CTRL, sel, d);
            if (!d[16] || polls > 50) break;
            polls++;
            @(negedge clk);
        end
    endtask

    task automatic results(bit sel, output longint b, output longint p, output logic [31:0] w2);
        logic [31:0] r0, r1;
        rreg(A_RES0, sel, r0);
        rreg(A_RES1, sel, r1);
        rreg(A_RES2, sel, w2);
        b = {r1[15:0], r0};
        p = {w2[23:0], r1[31:16]};
    endtask

    task automatic rd(int idx, bit sel, output longint b, output longint p, output int polls);
        logic [31:0] w2;
        @(negedge clk); rwr = 1; raddr = A_CTRL; rwdata = 32'h10000 | 32'(idx);
        @(negedge clk); rwr = 0;
        poll(sel, polls);
        results(sel, b, p, w2);
    endtask

    task automatic rd_chk(int idx, string tag);
        longint b, p;
        int pl;
        rd(idx, 0, b, p, pl);
        chk({tag, " bytes"}, b, eb[idx]);
        chk({tag, " packets"}, p, ep[idx]);
        if (mclr) begin eb[idx] = 0; ep[idx] = 0; end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        longint b, p;
        int pl;
        void'($urandom(32'd20240611));
        for (int k = 0; k < N; k++) begin eb[k] = 0; ep[k] = 0; end

        repeat (5) @(negedge clk);
        rst = 0;

        // R1: reset state
        rreg(A_CFG, 0, d);  chk("R1 cfg", d, 0);
        rreg(A_CTRL, 0, d); chk("R1 ctrl", d, 0);
        rd(3, 0, b, p, pl);
        chk("R1 entry bytes", b, 0);
        chk("R1 entry packets", p, 0);
        chk("R3 busy span", pl, LAT);

        // R5 gating by flag, R2 index readback, R6 retained without clear
        wreg(A_CFG, 1); men = 1;
        rreg(A_CFG, 0, d); chk("R5 cfg enable readback", d, 1);
        send(2, 100, 1); send(2, 50, 1); send(2, 7, 0); quiet();
        rd_chk(2, "R5 flag gating");
        rreg(A_CTRL, 0, d); chk("R2 index readback", d[13:0], 2);
        chk("R2 busy clear", d[16], 0);
        rd_chk(2, "R6 no clear keeps value");

        // R4: counts beyond 32 and 16 bits
        for (int k = 0; k < 65600; k++) send(9, 65535, 1);
        quiet();
        begin
            logic [31:0] w2;
            rd(9, 0, b, p, pl);
            results(0, b, p, w2);
            chk("R4 byte split", b, eb[9]);
            chk("R4 packet split", p, ep[9]);
            chk("R4 result2 upper zero", w2[31:24], 0);
        end

        // R5: global enable off
        wreg(A_CFG, 0); men = 0;
        send(4, 10, 1); quiet();
        rd_chk(4, "R5 global disable");

        // R6: read-to-clear
        wreg(A_CFG, 3); men = 1; mclr = 1;
        send(6, 20, 1); send(6, 20, 1); send(6, 20, 1); quiet();
        rd_chk(6, "R6 first read");
        rd_chk(6, "R6 after clear");

        // R10: aliasing
        send(16 + 7, 33, 1); quiet();
        rd_chk(7, "R10 alias");

        // R8: start while busy ignored
        send(1, 11, 1); send(12, 22, 1); quiet();
        @(negedge clk); rwr = 1; raddr = A_CTRL; rwdata = 32'h10000 | 32'd1;
        @(negedge clk); rwdata = 32'h10000 | 32'd12;
        @(negedge clk); rwr = 0;
        poll(0, pl);
        begin
            logic [31:0] w2;
            results(0, b, p, w2);
        end
        chk("R8 bytes of first index", b, 11);
        chk("R8 packets of first index", p, 1);
        rreg(A_CTRL, 0, d); chk("R8 latched index", d[13:0], 1);
        eb[1] = 0; ep[1] = 0;
        rd_chk(12, "R8 second index untouched");

        // R7: packet in the clearing cycle
        send(5, 40, 1); quiet();
        @(negedge clk); rwr = 1; raddr = A_CTRL; rwdata = 32'h10000 | 32'd5;
        @(negedge clk); rwr = 0;
        repeat (LAT - 1) @(negedge clk);
        v0 = 1; i0 = 14'd5; l0 = 16'd9; f0 = 1;
        @(negedge clk); v0 = 0;
        rreg(A_CTRL, 0, d); chk("R7 read done", d[16], 0);
        begin
            logic [31:0] w2;
            results(0, b, p, w2);
        end
        chk("R7 returned bytes", b, 40);
        chk("R7 returned packets", p, 1);
        eb[5] = 9; ep[5] = 1;
        rd_chk(5, "R7 packet kept");

        // R5 R10: random traffic with enable bursts
        wreg(A_CFG, 1); mclr = 0;
        for (int burst = 0; burst < 3; burst++) begin
            for (int k = 0; k < 120; k++)
                send($urandom % 32, $urandom % 65536, ($urandom % 5) != 0);
            quiet();
            men = (burst != 0);
            wreg(A_CFG, men ? 32'd1 : 32'd0);
        end
        wreg(A_CFG, 3); mclr = 1;
        for (int k = 0; k < N; k++) rd_chk(k, "R5 R10 random entry");

        // R9: saturation on narrow instance
        wreg(A_CFG, 1);
        for (int k = 0; k < 1050; k++) begin
            @(negedge clk); v1 = 1; i1 = 0; f1 = 1; l1 = (k < 20) ? 16'hFFFF : 16'd0;
        end
        quiet();
        rd(0, 1, b, p, pl);
        chk("R9 byte saturation", b, sat(20 * 65535, 20));
        chk("R9 packet saturation", p, sat(1050, 10));

        summary();
        $finish;
    end

endmodule